// File: doc/BRIEF.md
# Windowed Interrupt Configuration Register Bank

This block holds a 3-bit priority for each of 128 interrupt requests and exports all of them at once: a flattened priority vector, and an enable vector whose bit is set for any request with a nonzero priority. Software reaches the priorities indirectly over a small byte-wide register bus. A group select register picks one group of eight requests. Those eight priorities then appear as eight consecutive data registers.

The select value is the upper nibble of the low byte of a request's vector address, with 2-byte vectors. Select value S therefore covers request numbers 8*S to 8*S+7, and data offset k reaches request 8*S+k. Group 0 has no configuration storage. When the select field is zero, the window is inert. Requests 0 to 7 stay disabled.

Top module: `intcfg_bank`

## Requirements
- R1: Local address 0 is the select register. Only bits 7:4 are stored. Bits 3:0 always read 0 and ignore writes.
- R2: After reset the select register reads 0x10. Every stored priority (requests 8 to 127) is 1, so those requests are enabled.
- R3: With select S nonzero, local address 1+k (k = 0..7) reads and writes the priority of request 8*S+k, in ascending order.
- R4: In a window byte only bits 2:0 are stored. Bits 7:3 read 0.
- R5: With select 0, writes to addresses 1 to 8 change nothing and reads of them return 0x00.
- R6: Requests 0 to 7 always export priority 0 and enable 0.
- R7: A request's enable output is 1 exactly when its priority is nonzero. Priority 0 disables the request, 1 is the lowest level and 7 the highest.
- R8: Local addresses 9 to 15 read 0x00, and writes to them change nothing.
- R9: A write takes effect at the rising clock edge where we_i is high. Read data is combinational. A new select value moves the window from the next cycle on.
- R10: A window write changes only the addressed request's priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write enable for the addressed register |
| addr_i | input | 4 | Local register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data |
| prio_o | output | 384 | Priority of request r at bits [3r+2:3r] |
| en_o | output | 128 | Enable of each request |

## Verification
The bench sweeps every nonzero select value and fills each window with distinct data. A design that reverses the window order or offsets the group by one would then move or corrupt values seen on the flattened vector. It writes the select register with nonzero low bits, so a design storing all eight bits reads back wrong. It writes the window while select is zero, and also writes the addresses above the window; a design that decodes either case loosely would change some priority. Writing priority 0 checks that the enable bit drops in the same cycle as the priority.

// File: rtl/intcfg_pkg.sv
`timescale 1ns/1ps
package intcfg_pkg;
  localparam int unsigned PRIO_W   = 3;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned PRIO_RST = 1;
  localparam int unsigned SEL_RST  = 1;
  typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/intcfg_sel_reg.sv
`timescale 1ns/1ps
module intcfg_sel_reg #(
  parameter int unsigned SEL_W   = 4,
  parameter int unsigned RST_VAL = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] wsel_i,
  output logic [SEL_W-1:0] sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sel_o <= SEL_W'(RST_VAL);
    else if (we_i) sel_o <= wsel_i;
  end
endmodule

// File: rtl/intcfg_group.sv
`timescale 1ns/1ps
module intcfg_group
  import intcfg_pkg::*;
#(
  parameter int unsigned WIN   = 8,
  localparam int unsigned IDX_W = $clog2(WIN)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  prio_t                   wprio_i,
  output logic [WIN*PRIO_W-1:0]   prio_o
);
  for (genvar k = 0; k < WIN; k++) begin : g_slot
    prio_t q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  q <= prio_t'(PRIO_RST);
      else if (we_i && (idx_i == IDX_W'(k)))        q <= wprio_i;
    end
    assign prio_o[k*PRIO_W +: PRIO_W] = q;
  end
endmodule

// File: rtl/intcfg_rd_mux.sv
`timescale 1ns/1ps
module intcfg_rd_mux
  import intcfg_pkg::*;
#(
  parameter int unsigned NUM_REQ = 128,
  parameter int unsigned WIN     = 8,
  localparam int unsigned SEL_W  = $clog2(NUM_REQ/WIN),
  localparam int unsigned IDX_W  = $clog2(WIN),
  localparam int unsigned REQ_W  = SEL_W + IDX_W
) (
  input  logic                        sel_hit_i,
  input  logic                        win_hit_i,
  input  logic [SEL_W-1:0]            sel_i,
  input  logic [IDX_W-1:0]            idx_i,
  input  logic [NUM_REQ*PRIO_W-1:0]   prio_i,
  output logic [DATA_W-1:0]           rdata_o
);
  logic [REQ_W-1:0] req;
  prio_t            cur;

  assign req = {sel_i, idx_i};
  assign cur = prio_i[req*PRIO_W +: PRIO_W];

  always_comb begin
    rdata_o = '0;
    if (sel_hit_i)
      rdata_o = {sel_i, {(DATA_W-SEL_W){1'b0}}};
    else if (win_hit_i && (sel_i != '0))
      rdata_o = {{(DATA_W-PRIO_W){1'b0}}, cur};
  end
endmodule

// File: rtl/intcfg_bank.sv
`timescale 1ns/1ps
module intcfg_bank
  import intcfg_pkg::*;
#(
  parameter int unsigned NUM_REQ = 128,
  parameter int unsigned WIN     = 8,
  localparam int unsigned NUM_GRP = NUM_REQ / WIN,
  localparam int unsigned SEL_W   = $clog2(NUM_GRP),
  localparam int unsigned IDX_W   = $clog2(WIN),
  localparam int unsigned ADDR_W  = $clog2(WIN + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [DATA_W-1:0]         rdata_o,
  output logic [NUM_REQ*PRIO_W-1:0] prio_o,
  output logic [NUM_REQ-1:0]        en_o
);
  logic             sel_hit, win_hit;
  logic [IDX_W-1:0] idx;
  logic [SEL_W-1:0] sel_q;

  assign sel_hit = (addr_i == '0);
  assign win_hit = (addr_i != '0) && (addr_i <= ADDR_W'(WIN));
  assign idx     = IDX_W'(addr_i - ADDR_W'(1));

  intcfg_sel_reg #(.SEL_W(SEL_W), .RST_VAL(SEL_RST)) i_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i && sel_hit),
    .wsel_i (wdata_i[DATA_W-1 -: SEL_W]),
    .sel_o  (sel_q)
  );

  // group 0 maps to nonexistent registers: no storage, outputs tied off
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    if (g == 0) begin : g_none
      assign prio_o[0 +: WIN*PRIO_W] = '0;
    end else begin : g_cfg
      intcfg_group #(.WIN(WIN)) i_grp (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (we_i && win_hit && (sel_q == SEL_W'(g))),
        .idx_i   (idx),
        .wprio_i (wdata_i[PRIO_W-1:0]),
        .prio_o  (prio_o[g*WIN*PRIO_W +: WIN*PRIO_W])
      );
    end
  end

  for (genvar r = 0; r < NUM_REQ; r++) begin : g_en
    assign en_o[r] = |prio_o[r*PRIO_W +: PRIO_W];
  end

  intcfg_rd_mux #(.NUM_REQ(NUM_REQ), .WIN(WIN)) i_rd (
    .sel_hit_i (sel_hit),
    .win_hit_i (win_hit),
    .sel_i     (sel_q),
    .idx_i     (idx),
    .prio_i    (prio_o),
    .rdata_o   (rdata_o)
  );
endmodule

// File: rtl/intcfg_bank_chk.sv
`timescale 1ns/1ps
module intcfg_bank_chk
  import intcfg_pkg::*;
#(
  parameter int unsigned NUM_REQ = 128,
  parameter int unsigned WIN     = 8,
  localparam int unsigned SEL_W  = $clog2(NUM_REQ/WIN),
  localparam int unsigned IDX_W  = $clog2(WIN),
  localparam int unsigned ADDR_W = $clog2(WIN + 1),
  localparam int unsigned REQ_W  = SEL_W + IDX_W
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      we_i,
  input logic [ADDR_W-1:0]         addr_i,
  input logic [DATA_W-1:0]         wdata_i,
  input logic [DATA_W-1:0]         rdata_o,
  input logic [NUM_REQ*PRIO_W-1:0] prio_o,
  input logic [NUM_REQ-1:0]        en_o
);
  logic             in_win;
  logic [SEL_W-1:0] sel_m;
  logic             last_vld;
  logic [REQ_W-1:0] last_idx;
  prio_t            last_dat;

  assign in_win = (addr_i >= ADDR_W'(1)) && (addr_i <= ADDR_W'(WIN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_m    <= SEL_W'(SEL_RST);
      last_vld <= 1'b0;
      last_idx <= '0;
      last_dat <= '0;
    end else begin
      if (we_i && addr_i == '0) sel_m <= wdata_i[DATA_W-1 -: SEL_W];
      last_vld <= we_i && in_win && (sel_m != '0);
      last_idx <= {sel_m, IDX_W'(addr_i - ADDR_W'(1))};
      last_dat <= wdata_i[PRIO_W-1:0];
    end
  end

  // R1
  sel_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == '0) |-> (rdata_o == {sel_m, {(DATA_W-SEL_W){1'b0}}}));
  // R4
  win_rsvd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_win |-> (rdata_o[DATA_W-1:PRIO_W] == '0));
  // R5
  sel0_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && in_win && sel_m == '0) |=> $stable(prio_o));
  // R6
  grp0_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prio_o[WIN*PRIO_W-1:0] == '0) && (en_o[WIN-1:0] == '0));
  // R8
  unmapped_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i > ADDR_W'(WIN)) |-> (rdata_o == '0));
  // R9
  wr_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_vld |-> (prio_o[last_idx*PRIO_W +: PRIO_W] == last_dat));
  // R7
  en_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_vld |-> (en_o[last_idx] == (last_dat != '0)));
endmodule

bind intcfg_bank intcfg_bank_chk #(.NUM_REQ(NUM_REQ), .WIN(WIN)) i_chk (.*);

// File: tb/test_intcfg_bank.sv
`timescale 1ns/1ps
module test_intcfg_bank;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         we_i = 1'b0;
  logic [3:0]   addr_i = '0;
  logic [7:0]   wdata_i = '0;
  logic [7:0]   rdata_o;
  logic [383:0] prio_o;
  logic [127:0] en_o;

  intcfg_bank i_intcfg_bank (.*);

  always #4 clk_i = ~clk_i;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  int ref_prio [128];
  int ref_sel;

  function automatic int ref_rd(int a);
    if (a == 0) return ref_sel * 16;
    if (a >= 1 && a <= 8 && ref_sel != 0) return ref_prio[ref_sel*8 + a - 1];
    return 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_outs(string req);
    int bad_p = -1;
    for (int r = 0; r < 128; r++)
      if (int'(prio_o[r*3 +: 3]) != ref_prio[r] || en_o[r] != (ref_prio[r] != 0)) begin
        bad_p = r; break;
      end
    n_chk++;
    if (bad_p >= 0) begin
      n_bad++;
      $display("FAIL %s req %0d actual prio=%0d en=%0b expected prio=%0d en=%0b", req, bad_p,
               prio_o[bad_p*3 +: 3], en_o[bad_p], ref_prio[bad_p], ref_prio[bad_p] != 0);
    end
  endtask

  // one bus cycle: check combinational read, then state after the edge
  task automatic bus(bit we, int a, int d, string req);
    string rq;
    @(negedge clk_i);
    we_i = we; addr_i = 4'(a); wdata_i = 8'(d);
    #1;
    if (a == 0) rq = "R1"; else if (a > 8) rq = "R8";
    else if (ref_sel == 0) rq = "R5"; else rq = "R3/R4";
    chk(rq, int'(rdata_o), ref_rd(a));
    @(posedge clk_i);
    if (we) begin
      if (a == 0) ref_sel = (d >> 4) & 15;
      else if (a <= 8 && ref_sel != 0) ref_prio[ref_sel*8 + a - 1] = d & 7;
    end
    #1;
    chk_outs(req);
    we_i = 1'b0;
  endtask

  initial begin
    #1600000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 128; r++) ref_prio[r] = (r < 8) ? 0 : 1;
    ref_sel = 1;
    #20 rst_ni = 1'b1;
    // R2 reset state
    #1 chk("R2", int'(rdata_o), 8'h10);
    chk_outs("R2");
    chk("R6", int'(prio_o[23:0]), 0);
    // R1 low nibble of select ignored
    bus(1, 0, 8'h3F, "R1");
    bus(0, 0, 0, "R1");
    // R3 R9 R10 fill every group with distinct values, read back
    for (int s = 1; s < 16; s++) begin
      bus(1, 0, s*16 + 10, "R9");
      for (int k = 0; k < 8; k++) bus(1, k + 1, (s*29 + k*11 + 3) & 255, "R10");
    end
    for (int s = 15; s >= 1; s--) begin
      bus(1, 0, s*16, "R9");
      for (int k = 0; k < 8; k++) bus(0, k + 1, 0, "R3");
    end
    // R7 zero priority disables, seven is highest
    bus(1, 0, 8'h70, "R7");
    bus(1, 1, 8'hF8, "R7");
    chk("R7", int'(en_o[56]), 0);
    bus(1, 8, 8'h07, "R7");
    chk("R7", int'(en_o[63]), 1);
    // R5 select zero: writes dropped, reads zero
    bus(1, 0, 8'h05, "R5");
    for (int k = 1; k <= 8; k++) bus(1, k, 8'h06, "R5");
    // R8 addresses above the window
    bus(1, 0, 8'h20, "R8");
    for (int a = 9; a < 16; a++) bus(1, a, 8'hFF, "R8");
    bus(0, 1, 0, "R8");
    chk("R6", int'(en_o[7:0]), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule